// File: doc/BRIEF.md
# Four-Level Nested Interrupt Arbiter

This block collects twelve interrupt request lines of an 8-bit processor and decides, at each instruction boundary, whether one of them is handed to the core. Two of the lines come from active-low external pins. Each of those pins can be set to act on its level or on a falling edge. The other ten lines are level requests held by on-chip peripherals until their handlers clear them.

Each source has its own enable bit, and a global enable gates every source. Each source gets one of four priority levels from a pair of bits, one in a high-order bank and one in a low-order bank. A small in-service mask records which levels have handlers running, so a new request preempts only when its level is strictly above the highest active one. The core reports handler exit with a return strobe.

While the processor sleeps, an enabled external request drives a wake output.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `irq` and `wake` are 0, and the in-service mask is empty, so the first request at any level is accepted.
- R2: A source is a candidate only when its `src_en` bit is 1 and `glb_en` is 1. A masked source never raises `irq`.
- R3: A source's level is `{prio_hi[i], prio_lo[i]}`, with 3 the highest and 0 the lowest. Among candidates, the one at the highest level is taken.
- R4: Among candidates at the same level, the lowest index wins. The indices are: 0 external pin 0, 1 external pin 1, 2 timer 0, 3 timer 1, 4 serial transmit, 5 serial receive, 6 combined serial, 7 brownout, 8 watchdog/real-time clock, 9 I2C bus, 10 keyboard, 11 comparators. Index i of `per_req` is source i+2.
- R5: A request is taken only in a cycle with `insn_bnd`=1 and `reti`=0. `irq` is then 1 for the following cycle, with `irq_vec` equal to the source index and `irq_lvl` equal to its level, and that level is marked in service.
- R6: While handlers are in service, a candidate is taken only if its level is strictly above the highest in-service level.
- R7: While level 3 is in service, no request is taken.
- R8: A `reti` pulse clears only the highest set bit of the in-service mask. The lower nested levels stay marked.
- R9: With `ext_edge` bit k = 1, a pin sampled high in one cycle and low in the next sets a latched flag. The flag requests even after the pin returns high, and it is cleared when that source is taken.
- R10: With `ext_edge` bit k = 0, the request is the inverted sampled pin with no latch. A low pulse that has ended leaves no request.
- R11: `wake` is 1 only while `low_pwr` is 1, `glb_en` is 1, and an enabled external source is requesting. Peripheral requests never drive `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 2 | Active-low external interrupt pins |
| ext_edge | input | 2 | Per-pin mode: 1 falling edge, 0 level |
| per_req | input | 10 | Peripheral request lines, sources 2 to 11 |
| src_en | input | 12 | Per-source enable |
| glb_en | input | 1 | Global enable |
| prio_hi | input | 12 | Upper bit of each source's level |
| prio_lo | input | 12 | Lower bit of each source's level |
| insn_bnd | input | 1 | Instruction boundary strobe |
| reti | input | 1 | Return-from-handler strobe |
| low_pwr | input | 1 | Core is in idle or power-down |
| irq | output | 1 | One-cycle request to the core |
| irq_vec | output | 4 | Index of the taken source |
| irq_lvl | output | 2 | Level of the taken source |
| wake | output | 1 | Wake request while sleeping |

## Verification
Every pair of peripheral sources is swept across all sixteen level combinations. This separates the level comparison from the index tie-break, and a swapped bank or a reversed order shows up as a wrong vector. A nested sweep covers every in-service level against every new level, which exposes an off-by-one preemption test or a missing top-level block. A three-deep sequence with a single return shows whether the highest or the lowest in-service bit is cleared. On the external pins, short pulses, held lows and released lows are applied in both modes, which tells a latched edge flag from a transparent level path. The wake output is probed under each gating condition.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned NUM_SRC = 12;
  localparam int unsigned NUM_EXT = 2;
  localparam int unsigned NUM_LVL = 4;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);
  localparam int unsigned LVL_W   = $clog2(NUM_LVL);

  typedef enum logic [IDX_W-1:0] {
    SRC_PIN0  = 4'd0,
    SRC_PIN1  = 4'd1,
    SRC_TMR0  = 4'd2,
    SRC_TMR1  = 4'd3,
    SRC_STX   = 4'd4,
    SRC_SRX   = 4'd5,
    SRC_SCOMB = 4'd6,
    SRC_BOD   = 4'd7,
    SRC_WDRT  = 4'd8,
    SRC_I2C   = 4'd9,
    SRC_KBD   = 4'd10,
    SRC_CMP   = 4'd11
  } src_id_e;
endpackage

// File: rtl/irq_ext_sense.sv
module irq_ext_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic ack,
  output logic req
);
  logic pin_q, pin_qq, flag_q;
  logic flag_d, fall;

  assign fall = pin_qq & ~pin_q;

  always_comb begin
    flag_d = flag_q;
    if (!edge_mode) begin
      flag_d = 1'b0;
    end else begin
      if (ack)  flag_d = 1'b0;
      if (fall) flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b1;
      pin_qq <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      pin_q  <= pin_n;
      pin_qq <= pin_q;
      flag_q <= flag_d;
    end
  end

  assign req = edge_mode ? flag_q : ~pin_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned NUM_SRC = 12,
  parameter int unsigned NUM_LVL = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC),
  localparam int unsigned LVL_W  = $clog2(NUM_LVL)
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] prio_hi,
  input  logic [NUM_SRC-1:0] prio_lo,
  output logic               cand_vld,
  output logic [IDX_W-1:0]   cand_idx,
  output logic [LVL_W-1:0]   cand_lvl
);
  logic [LVL_W-1:0] src_lvl [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
    assign src_lvl[g] = {prio_hi[g], prio_lo[g]};
  end

  always_comb begin
    cand_vld = 1'b0;
    cand_idx = '0;
    cand_lvl = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (!cand_vld) begin
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
          if (pend[i] && src_lvl[i] == LVL_W'(l)) begin
            cand_vld = 1'b1;
            cand_idx = IDX_W'(i);
            cand_lvl = LVL_W'(l);
          end
        end
      end
    end
  end
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track #(
  parameter int unsigned NUM_LVL = 4,
  localparam int unsigned LVL_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [LVL_W-1:0]   take_lvl,
  input  logic               reti,
  output logic [NUM_LVL-1:0] isr_q,
  output logic               busy,
  output logic [LVL_W-1:0]   top_lvl
);
  logic [NUM_LVL-1:0] isr_d;

  always_comb begin
    top_lvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (isr_q[l]) top_lvl = LVL_W'(l);
    end
  end

  assign busy = |isr_q;

  always_comb begin
    isr_d = isr_q;
    if (reti) begin
      if (busy) isr_d[top_lvl] = 1'b0;
    end else if (take) begin
      isr_d[take_lvl] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned N_EXT = NUM_EXT,
  parameter int unsigned N_LVL = NUM_LVL,
  localparam int unsigned IW   = $clog2(N_SRC),
  localparam int unsigned LW   = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_pin_n,
  input  logic [N_EXT-1:0] ext_edge,
  input  logic [N_SRC-N_EXT-1:0] per_req,
  input  logic [N_SRC-1:0] src_en,
  input  logic             glb_en,
  input  logic [N_SRC-1:0] prio_hi,
  input  logic [N_SRC-1:0] prio_lo,
  input  logic             insn_bnd,
  input  logic             reti,
  input  logic             low_pwr,
  output logic             irq,
  output logic [IW-1:0]    irq_vec,
  output logic [LW-1:0]    irq_lvl,
  output logic             wake
);
  logic [N_EXT-1:0] ext_req;
  logic [N_SRC-1:0] pend;
  logic             cand_vld;
  logic [IW-1:0]    cand_idx;
  logic [LW-1:0]    cand_lvl;
  logic [N_LVL-1:0] isr_vec;
  logic             isr_busy;
  logic [LW-1:0]    isr_top;
  logic             take;
  logic             irq_q, irq_d;
  logic [IW-1:0]    vec_q, vec_d;
  logic [LW-1:0]    lvl_q, lvl_d;

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    irq_ext_sense u_sense (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (ext_pin_n[g]),
      .edge_mode (ext_edge[g]),
      .ack       (take && cand_idx == IW'(g)),
      .req       (ext_req[g])
    );
  end

  assign pend = {per_req, ext_req} & src_en & {N_SRC{glb_en}};

  irq_arbiter #(.NUM_SRC(N_SRC), .NUM_LVL(N_LVL)) u_arb (
    .pend     (pend),
    .prio_hi  (prio_hi),
    .prio_lo  (prio_lo),
    .cand_vld (cand_vld),
    .cand_idx (cand_idx),
    .cand_lvl (cand_lvl)
  );

  assign take = insn_bnd && !reti && cand_vld && (!isr_busy || cand_lvl > isr_top);

  irq_nest_track #(.NUM_LVL(N_LVL)) u_nest (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .take_lvl (cand_lvl),
    .reti     (reti),
    .isr_q    (isr_vec),
    .busy     (isr_busy),
    .top_lvl  (isr_top)
  );

  always_comb begin
    irq_d = take;
    vec_d = vec_q;
    lvl_d = lvl_q;
    if (take) begin
      vec_d = cand_idx;
      lvl_d = cand_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= '0;
    end else begin
      irq_q <= irq_d;
      vec_q <= vec_d;
      lvl_q <= lvl_d;
    end
  end

  assign irq     = irq_q;
  assign irq_vec = vec_q;
  assign irq_lvl = lvl_q;
  assign wake    = low_pwr && glb_en && |(ext_req & src_en[N_EXT-1:0]);
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned N_LVL = 4,
  localparam int unsigned LW   = $clog2(N_LVL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [LW-1:0]    irq_lvl,
  input logic             insn_bnd,
  input logic             reti,
  input logic             glb_en,
  input logic             low_pwr,
  input logic             wake,
  input logic [N_LVL-1:0] isr_q,
  input logic             busy,
  input logic [LW-1:0]    top_lvl
);
  // R5
  irq_after_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(insn_bnd) && !$past(reti)));

  // R5
  irq_marks_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> isr_q[irq_lvl]);

  // R2
  glb_off_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !irq);

  // R6
  strict_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!$past(busy) || irq_lvl > $past(top_lvl)));

  // R7
  top_level_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr_q[N_LVL-1] |=> !irq);

  // R8
  reti_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && busy) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));

  // R11
  wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (low_pwr && glb_en));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_LVL(N_LVL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .irq_lvl  (irq_lvl),
  .insn_bnd (insn_bnd),
  .reti     (reti),
  .glb_en   (glb_en),
  .low_pwr  (low_pwr),
  .wake     (wake),
  .isr_q    (isr_vec),
  .busy     (isr_busy),
  .top_lvl  (isr_top)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic [1:0]  ext_pin_n;
  logic [1:0]  ext_edge;
  logic [9:0]  per_req;
  logic [11:0] src_en;
  logic        glb_en;
  logic [11:0] prio_hi;
  logic [11:0] prio_lo;
  logic        insn_bnd;
  logic        reti;
  logic        low_pwr;
  logic        irq;
  logic [3:0]  irq_vec;
  logic [1:0]  irq_lvl;
  logic        wake;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  logic got;
  logic [3:0] gvec;
  logic [1:0] glvl;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge(ext_edge),
    .per_req(per_req), .src_en(src_en), .glb_en(glb_en), .prio_hi(prio_hi),
    .prio_lo(prio_lo), .insn_bnd(insn_bnd), .reti(reti), .low_pwr(low_pwr),
    .irq(irq), .irq_vec(irq_vec), .irq_lvl(irq_lvl), .wake(wake)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) insn_bnd = 1'b1;
    @(negedge clk) insn_bnd = 1'b0;
    got  = irq;
    gvec = irq_vec;
    glvl = irq_lvl;
  endtask

  task automatic do_reti();
    @(negedge clk) reti = 1'b1;
    @(negedge clk) reti = 1'b0;
  endtask

  task automatic set_lvl(input int s, input int l);
    prio_hi[s] = l[1];
    prio_lo[s] = l[0];
  endtask

  task automatic clear_all();
    ext_pin_n = 2'b11; ext_edge = 2'b00; per_req = '0; src_en = '0;
    glb_en = 1'b1; prio_hi = '0; prio_lo = '0; low_pwr = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    insn_bnd = 1'b0; reti = 1'b0;
    clear_all();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    chk(wake == 1'b0, "R1 wake", int'(wake), 0);
    src_en[3] = 1'b1; set_lvl(3, 0); per_req[1] = 1'b1; idle(1);
    strobe();
    chk(got && gvec == 4'd3, "R1 first accept", int'(gvec), 3);
    per_req = '0; do_reti(); idle(1);

    // R3 R4 pair sweep over peripheral sources and levels
    for (int i = 2; i < 12; i++) begin
      for (int j = i + 1; j < 12; j++) begin
        for (int li = 0; li < 4; li++) begin
          for (int lj = 0; lj < 4; lj++) begin
            clear_all();
            src_en[i] = 1'b1; src_en[j] = 1'b1;
            set_lvl(i, li); set_lvl(j, lj);
            per_req[i-2] = 1'b1; per_req[j-2] = 1'b1;
            idle(1);
            strobe();
            begin
              int ev, el;
              ev = (lj > li) ? j : i;
              el = (lj > li) ? lj : li;
              chk(got == 1'b1, "R5 taken", int'(got), 1);
              chk(int'(gvec) == ev, "R3/R4 vector", int'(gvec), ev);
              chk(int'(glvl) == el, "R3 level", int'(glvl), el);
            end
            per_req = '0;
            do_reti();
          end
        end
      end
    end

    // R2 masking sweep
    for (int i = 2; i < 12; i++) begin
      for (int m = 0; m < 3; m++) begin
        clear_all();
        set_lvl(i, 2);
        per_req[i-2] = 1'b1;
        src_en[i] = (m != 0);
        glb_en = (m != 1);
        idle(1);
        strobe();
        chk(got == (m == 2), "R2 mask", int'(got), int'(m == 2));
        per_req = '0;
        if (got) do_reti();
      end
    end

    // R5 no strobe means no request, and reti blocks a strobe
    clear_all();
    src_en[4] = 1'b1; per_req[2] = 1'b1; idle(4);
    chk(irq == 1'b0, "R5 no boundary", int'(irq), 0);
    @(negedge clk) begin insn_bnd = 1'b1; reti = 1'b1; end
    @(negedge clk) begin insn_bnd = 1'b0; reti = 1'b0; end
    chk(irq == 1'b0, "R5 reti blocks", int'(irq), 0);
    idle(1);
    chk(irq == 1'b0, "R5 single pulse", int'(irq), 0);
    per_req = '0;

    // R6 R7 nesting sweep
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        clear_all();
        src_en[2] = 1'b1; src_en[5] = 1'b1;
        set_lvl(2, a); set_lvl(5, b);
        per_req[0] = 1'b1; idle(1);
        strobe();
        chk(got && gvec == 4'd2, "R6 first", int'(gvec), 2);
        per_req[0] = 1'b0; per_req[3] = 1'b1; idle(1);
        strobe();
        chk(got == (b > a), (a == 3) ? "R7 top level blocks" : "R6 preempt",
            int'(got), int'(b > a));
        per_req = '0;
        if (got) do_reti();
        do_reti();
      end
    end

    // R8 only the highest in-service level is cleared
    clear_all();
    src_en[2] = 1'b1; src_en[3] = 1'b1; src_en[4] = 1'b1;
    set_lvl(2, 1); set_lvl(3, 3); set_lvl(4, 2);
    per_req[0] = 1'b1; idle(1); strobe(); per_req[0] = 1'b0;
    per_req[1] = 1'b1; idle(1); strobe(); per_req[1] = 1'b0;
    chk(got && glvl == 2'd3, "R8 nest to 3", int'(glvl), 3);
    do_reti();
    per_req[2] = 1'b1; idle(1); strobe(); per_req[2] = 1'b0;
    chk(got && gvec == 4'd4, "R8 level 2 over 1", int'(gvec), 4);
    do_reti(); do_reti();
    set_lvl(2, 0);
    per_req[0] = 1'b1; idle(1); strobe(); per_req[0] = 1'b0;
    chk(got == 1'b1, "R8 all cleared", int'(got), 1);
    do_reti();

    // R9 edge mode
    clear_all();
    ext_edge[0] = 1'b1; src_en[0] = 1'b1; set_lvl(0, 1); idle(3);
    strobe();
    chk(got == 1'b0, "R9 no edge yet", int'(got), 0);
    @(negedge clk) ext_pin_n[0] = 1'b0;
    @(negedge clk) ext_pin_n[0] = 1'b1;
    idle(3);
    strobe();
    chk(got && gvec == 4'd0 && glvl == 2'd1, "R9 latched pulse", int'(gvec), 0);
    do_reti();
    strobe();
    chk(got == 1'b0, "R9 flag cleared", int'(got), 0);
    @(negedge clk) ext_pin_n[0] = 1'b0;
    idle(3);
    strobe();
    chk(got == 1'b1, "R9 held low edge", int'(got), 1);
    do_reti();
    strobe();
    chk(got == 1'b0, "R9 held low no retrigger", int'(got), 0);

    // R10 level mode
    clear_all();
    src_en[1] = 1'b1; set_lvl(1, 2);
    @(negedge clk) ext_pin_n[1] = 1'b0;
    idle(2);
    strobe();
    chk(got && gvec == 4'd1, "R10 low requests", int'(gvec), 1);
    do_reti();
    strobe();
    chk(got == 1'b1, "R10 still low", int'(got), 1);
    do_reti();
    @(negedge clk) ext_pin_n[1] = 1'b1;
    idle(2);
    strobe();
    chk(got == 1'b0, "R10 released", int'(got), 0);
    @(negedge clk) ext_pin_n[1] = 1'b0;
    @(negedge clk) ext_pin_n[1] = 1'b1;
    idle(3);
    strobe();
    chk(got == 1'b0, "R10 no latch", int'(got), 0);

    // R4 external pins tie at one level
    clear_all();
    src_en[1:0] = 2'b11; set_lvl(0, 2); set_lvl(1, 2);
    ext_pin_n = 2'b00; idle(3);
    strobe();
    chk(got && gvec == 4'd0, "R4 pin tie", int'(gvec), 0);
    do_reti();

    // R11 wake
    clear_all();
    low_pwr = 1'b1; src_en[1] = 1'b1; ext_pin_n[1] = 1'b0; idle(3);
    chk(wake == 1'b1, "R11 wake on", int'(wake), 1);
    glb_en = 1'b0; idle(1);
    chk(wake == 1'b0, "R11 global off", int'(wake), 0);
    glb_en = 1'b1; src_en[1] = 1'b0; idle(1);
    chk(wake == 1'b0, "R11 source off", int'(wake), 0);
    src_en[1] = 1'b1; low_pwr = 1'b0; idle(1);
    chk(wake == 1'b0, "R11 awake", int'(wake), 0);
    low_pwr = 1'b1; ext_pin_n[1] = 1'b1; src_en[6] = 1'b1; per_req[4] = 1'b1; idle(3);
    chk(wake == 1'b0, "R11 peripheral no wake", int'(wake), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule